// File: doc/BRIEF.md
# Backplane Interrupt Requester and Responder

This block is the interrupt front end of a plug-in I/O card that sits as a bus slave on a 68000-family backplane. The backplane has seven active-low request lines for levels 1 (lowest) to 7 (highest). Level 0 has no line because it is the quiet, non-interrupting state. A 2-bit configuration code fixes the card at one of the four levels 3 to 6. Card logic raises a request with a one-cycle pulse. The request is held on the selected line until a separate clear pulse withdraws it. The block only pulls lines low through output enables and never drives them high.

When the bus master runs an interrupt-acknowledge cycle, the block answers in one of two ways. In autovector mode, which is the reset default, it supplies nothing and the processor makes its own vector. In vectored mode it drives a configured 8-bit vector on the low data byte, pulls the vector-present strobe and pulls the data acknowledge. It does this only while its request is pending and only when the level on the three acknowledge address bits equals its own level. A bus-error signal from the master releases every driver at once. The block then stays off the bus until the acknowledge cycle ends. All bus inputs pass through two-flop synchronizers.

Top module: `irqf_top`

## Requirements
- R1: After the synchronous reset, no request is pending, all seven line enables are low, and the data, strobe and acknowledge enables are low with `data_o` at zero.
- R2: A pending request enables exactly one request line: `irq_oe` bit (L-1) for level L, where select code 0,1,2,3 gives level 3,4,5,6. Bits 0, 1 and 6 (levels 1, 2 and 7) are never enabled.
- R3: A `dev_raise` pulse makes the request pending from the next cycle. The request stays pending through acknowledge cycles and ends only on a `dev_clear` pulse. When both pulses arrive in the same cycle, clear wins.
- R4: With `vec_mode` = 0 (autovector), no driver is enabled during any acknowledge cycle.
- R5: With `vec_mode` = 1, a pending request and `ack_lvl` equal to the card's level, the outputs `data_oe`, `vecp_oe` and `dtack_oe` go high with `data_o` = `vec_val`. This happens on the third rising clock edge after `iack_n` falls.
- R6: In vectored mode, a mismatched `ack_lvl` or no pending request leaves all drivers off.
- R7: The drivers are released on the third rising edge after `iack_n` rises. This is one clock after the synchronized acknowledge deasserts.
- R8: While the block is driving, a fall of `berr_n` releases all drivers on the second rising edge after it. The drivers stay released until `iack_n` has gone high, even if `berr_n` returns high first.
- R9: `data_o` is zero whenever `data_oe` is low, and the three driver enables always change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_raise | input | 1 | One-cycle pulse from card logic that makes the request pending |
| dev_clear | input | 1 | One-cycle pulse that withdraws the request |
| lvl_sel | input | 2 | Level code: 0..3 selects level 3..6 |
| vec_mode | input | 1 | 0 = autovector, 1 = externally vectored |
| vec_val | input | 8 | Vector returned in vectored mode |
| iack_n | input | 1 | Interrupt acknowledge from the bus master, active low |
| ack_lvl | input | 3 | Level being acknowledged, from address bits |
| berr_n | input | 1 | Bus error from the master, active low |
| irq_oe | output | 7 | Pull-low enables for request lines of levels 1..7 (bit 0 = level 1) |
| data_o | output | 8 | Vector on the low data byte |
| data_oe | output | 1 | Enable for the low data byte |
| vecp_oe | output | 1 | Pull-low enable for the vector-present strobe |
| dtack_oe | output | 1 | Pull-low enable for the data acknowledge |

## Verification
Random acknowledge cycles draw the select code, mode, vector, acknowledge level and pending state independently. A bench function predicts whether the card answers, so the random cycles separate a matching level from a near miss, a pending request from an idle card, and vectored mode from autovector mode. Directed cases count the exact edges for the vector to appear and to be released. They also place a bus error in the middle of a drive and release the error while the acknowledge is still low, which shows that an abort does not re-arm inside the same cycle. A separate case sends simultaneous raise and clear pulses to show which one wins.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int NUM_LEVELS = 7;
    localparam int LVL_W      = 3;
    localparam int SEL_W      = 2;
    localparam int VEC_W      = 8;
    localparam int SEL_BASE   = 3;

    typedef enum logic {
        MODE_AUTO   = 1'b0,
        MODE_VECTOR = 1'b1
    } ack_mode_e;

    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_DRIVE   = 2'd1,
        RSP_HOLDOFF = 2'd2
    } rsp_state_e;

    // Bus view after synchronization, polarity made active high
    typedef struct packed {
        logic             iack;
        logic             berr;
        logic [LVL_W-1:0] lvl;
    } bus_view_t;

    typedef struct packed {
        logic             drive;
        logic [VEC_W-1:0] data;
    } vec_drive_t;

    function automatic logic [LVL_W-1:0] sel_to_level(input logic [SEL_W-1:0] sel);
        return LVL_W'(SEL_BASE) + LVL_W'(sel);
    endfunction

    function automatic logic [NUM_LEVELS-1:0] level_line(input logic [LVL_W-1:0] lvl);
        logic [NUM_LEVELS-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (lvl == LVL_W'(i + 1)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irqf_request.sv
module irqf_request
    import irqf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  raise,
    input  logic                  clear,
    input  logic [SEL_W-1:0]      sel,
    output logic                  pending,
    output logic [LVL_W-1:0]      my_level,
    output logic [NUM_LEVELS-1:0] line_oe
);
    always_ff @(posedge clk) begin
        if (rst)        pending <= 1'b0;
        else if (clear) pending <= 1'b0;
        else if (raise) pending <= 1'b1;
    end

    assign my_level = sel_to_level(sel);

    // Pull-low enable only; the line itself is never driven high
    always_comb begin
        line_oe = '0;
        if (pending) line_oe = level_line(my_level);
    end

    AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_oe)); // R2
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        !line_oe[0] && !line_oe[1] && !line_oe[NUM_LEVELS-1]); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pending); // R3
    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (raise && !clear) |=> pending); // R3
endmodule

// File: rtl/irqf_responder.sv
module irqf_responder
    import irqf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_view_t        bus,
    input  logic             pending,
    input  logic [LVL_W-1:0] my_level,
    input  ack_mode_e        mode,
    input  logic [VEC_W-1:0] vec,
    output vec_drive_t       drv
);
    rsp_state_e state, state_nx;
    logic       hit;

    assign hit = bus.iack && !bus.berr && pending &&
                 (mode == MODE_VECTOR) && (bus.lvl == my_level);

    always_comb begin
        state_nx = state;
        unique case (state)
            RSP_IDLE:    if (hit) state_nx = RSP_DRIVE;
            RSP_DRIVE: begin
                if (!bus.iack)     state_nx = RSP_IDLE;
                else if (bus.berr) state_nx = RSP_HOLDOFF;
            end
            RSP_HOLDOFF: if (!bus.iack) state_nx = RSP_IDLE;
            default:     state_nx = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RSP_IDLE;
        else     state <= state_nx;
    end

    // Bus error gates the drivers off in the cycle it is seen
    always_comb begin
        drv.drive = (state == RSP_DRIVE) && !bus.berr;
        drv.data  = drv.drive ? vec : '0;
    end

    AST_AUTO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == RSP_IDLE && mode == MODE_AUTO) |=> state != RSP_DRIVE); // R4
    AST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (state == RSP_IDLE && !pending) |=> state != RSP_DRIVE); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == RSP_DRIVE && !bus.iack) |=> state == RSP_IDLE); // R7
    AST_BERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        bus.berr |=> state != RSP_DRIVE); // R8
    AST_HOLDOFF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (state == RSP_HOLDOFF && bus.iack) |=> state == RSP_HOLDOFF); // R8
endmodule

// File: rtl/irqf_top.sv
module irqf_top
    import irqf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dev_raise,
    input  logic                  dev_clear,
    input  logic [SEL_W-1:0]      lvl_sel,
    input  logic                  vec_mode,
    input  logic [VEC_W-1:0]      vec_val,
    input  logic                  iack_n,
    input  logic [LVL_W-1:0]      ack_lvl,
    input  logic                  berr_n,
    output logic [NUM_LEVELS-1:0] irq_oe,
    output logic [VEC_W-1:0]      data_o,
    output logic                  data_oe,
    output logic                  vecp_oe,
    output logic                  dtack_oe
);
    localparam int                  SYNC_W   = LVL_W + 2;
    localparam logic [SYNC_W-1:0]   SYNC_RST = {2'b11, {LVL_W{1'b0}}};

    logic [SYNC_W-1:0] sync_q;
    bus_view_t         bus;
    logic              pending;
    logic [LVL_W-1:0]  my_level;
    vec_drive_t        drv;

    irqf_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({iack_n, berr_n, ack_lvl}),
        .q   (sync_q)
    );

    always_comb begin
        bus.iack = ~sync_q[SYNC_W-1];
        bus.berr = ~sync_q[SYNC_W-2];
        bus.lvl  = sync_q[LVL_W-1:0];
    end

    irqf_request u_req (
        .clk      (clk),
        .rst      (rst),
        .raise    (dev_raise),
        .clear    (dev_clear),
        .sel      (lvl_sel),
        .pending  (pending),
        .my_level (my_level),
        .line_oe  (irq_oe)
    );

    irqf_responder u_rsp (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .pending  (pending),
        .my_level (my_level),
        .mode     (ack_mode_e'(vec_mode)),
        .vec      (vec_val),
        .drv      (drv)
    );

    assign data_o   = drv.data;
    assign data_oe  = drv.drive;
    assign vecp_oe  = drv.drive;
    assign dtack_oe = drv.drive;

    AST_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> data_o == '0); // R9
    AST_ENABLES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (data_oe == vecp_oe) && (vecp_oe == dtack_oe)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (irq_oe == '0 && !dtack_oe)); // R1
endmodule

// File: tb/tb_irqf_top.sv
`timescale 1ns/1ps
module tb_irqf_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       dev_raise, dev_clear;
    logic [1:0] lvl_sel;
    logic       vec_mode;
    logic [7:0] vec_val;
    logic       iack_n;
    logic [2:0] ack_lvl;
    logic       berr_n;
    logic [6:0] irq_oe;
    logic [7:0] data_o;
    logic       data_oe, vecp_oe, dtack_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irqf_top dut (
        .clk(clk), .rst(rst), .dev_raise(dev_raise), .dev_clear(dev_clear),
        .lvl_sel(lvl_sel), .vec_mode(vec_mode), .vec_val(vec_val),
        .iack_n(iack_n), .ack_lvl(ack_lvl), .berr_n(berr_n),
        .irq_oe(irq_oe), .data_o(data_o), .data_oe(data_oe),
        .vecp_oe(vecp_oe), .dtack_oe(dtack_oe)
    );

    function automatic logic [6:0] exp_lines(input bit pend, input logic [1:0] sel);
        logic [6:0] v;
        v = '0;
        if (pend) v[32'(sel) + 2] = 1'b1;
        return v;
    endfunction

    function automatic bit exp_answer(input bit pend, input bit mode,
                                      input logic [1:0] sel, input logic [2:0] lvl);
        return pend && mode && (32'(lvl) == 32'(sel) + 3);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_drv(input string req, input bit on, input logic [7:0] v);
        check(req, "enables", {29'd0, data_oe, vecp_oe, dtack_oe}, on ? 32'd7 : 32'd0);
        check(req, "data_o", {24'd0, data_o}, on ? {24'd0, v} : 32'd0);
    endtask

    task automatic pulse_raise();
        dev_raise = 1'b1; tick(1); dev_raise = 1'b0;
    endtask

    task automatic pulse_clear();
        dev_clear = 1'b1; tick(1); dev_clear = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; dev_raise = 0; dev_clear = 0; lvl_sel = 2'd0; vec_mode = 0;
        vec_val = 8'h00; iack_n = 1; ack_lvl = 3'd0; berr_n = 1;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1", "irq_oe", {25'd0, irq_oe}, 32'd0);
        check_drv("R1", 0, 8'h00);

        // R2 level mapping for each code
        for (int s = 0; s < 4; s++) begin
            lvl_sel = 2'(s);
            pulse_raise();
            check("R2", "irq_oe", {25'd0, irq_oe}, {25'd0, exp_lines(1, 2'(s))});
            pulse_clear();
            check("R3", "cleared", {25'd0, irq_oe}, 32'd0);
        end

        // R3 clear wins over raise
        dev_raise = 1; dev_clear = 1; tick(1); dev_raise = 0; dev_clear = 0;
        check("R3", "clear wins", {25'd0, irq_oe}, 32'd0);

        // R5 exact latency, R7 release timing, R3 held through ack
        lvl_sel = 2'd2; vec_mode = 1; vec_val = 8'hA5; ack_lvl = 3'd5;
        pulse_raise();
        iack_n = 0;
        tick(2);
        check_drv("R5", 0, 8'hA5);
        tick(1);
        check_drv("R5", 1, 8'hA5);
        iack_n = 1;
        tick(2);
        check_drv("R7", 1, 8'hA5);
        tick(1);
        check_drv("R7", 0, 8'hA5);
        check("R3", "held after ack", {25'd0, irq_oe}, {25'd0, exp_lines(1, 2'd2)});

        // R8 bus error abort and hold-off
        iack_n = 0;
        tick(4);
        check_drv("R8", 1, 8'hA5);
        berr_n = 0;
        tick(1);
        check_drv("R8", 1, 8'hA5);
        tick(1);
        check_drv("R8", 0, 8'hA5);
        berr_n = 1;
        tick(5);
        check_drv("R8", 0, 8'hA5);
        iack_n = 1;
        tick(4);
        iack_n = 0;
        tick(4);
        check_drv("R8", 1, 8'hA5);
        iack_n = 1;
        tick(4);
        check_drv("R7", 0, 8'hA5);

        // R4 autovector stays quiet
        vec_mode = 0; iack_n = 0;
        tick(5);
        check_drv("R4", 0, 8'hA5);
        iack_n = 1; tick(4);

        // R6 mismatched level and idle card
        vec_mode = 1; ack_lvl = 3'd6; iack_n = 0;
        tick(5);
        check_drv("R6", 0, 8'hA5);
        iack_n = 1; tick(4);
        pulse_clear();
        ack_lvl = 3'd5; iack_n = 0;
        tick(5);
        check_drv("R6", 0, 8'hA5);
        iack_n = 1; tick(4);

        // Random acknowledge cycles, R5 R6 R4 R2 R9
        for (int it = 0; it < 60; it++) begin
            bit         pend, mode, ans;
            logic [1:0] sel;
            logic [2:0] lvl;
            logic [7:0] v;
            pend = 1'($urandom);
            mode = 1'($urandom);
            sel  = 2'($urandom);
            lvl  = ($urandom % 2) ? 3'(32'(sel) + 3) : 3'($urandom);
            v    = 8'($urandom);
            lvl_sel = sel; vec_mode = mode; vec_val = v;
            pulse_clear();
            if (pend) pulse_raise();
            check("R2", "random irq_oe", {25'd0, irq_oe}, {25'd0, exp_lines(pend, sel)});
            ack_lvl = lvl; iack_n = 0;
            tick(4);
            ans = exp_answer(pend, mode, sel, lvl);
            check_drv(ans ? "R5" : (mode ? "R6" : "R4"), ans, v);
            iack_n = 1;
            tick(4);
            check_drv("R9", 0, v);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule